// File: doc/BRIEF.md
# Transmit Clock Source Auto-Switch Controller

This block decides which clocks feed a line transmitter. Two clocks arrive from outside: a primary transmit clock and a fallback reference clock. A fast system clock watches each of them for activity. From what it sees, the block drives two select lines. The first picks the transmit clock, either the primary clock or the output of a local oscillator. The second picks the oscillator's reference, either the primary clock or the fallback clock. The oscillator, the glitch-free clock multiplexer and the elastic data buffer sit outside this block. It produces only the two selects and the status around them.

Both selections are revertive and share one loss detector for the primary clock. When the primary clock goes quiet and the auto-switch enable is set, both selects move away from it. They come back as soon as the primary clock shows activity again. Clearing the enable forces both selects to the primary clock at once, whatever state that clock is in.

Every change of a select sets a sticky event flag. Each flag has its own mask bit, and one interrupt line summarises the unmasked flags. Two live loss bits report the current state of each monitored clock.

Top module: `txclk_autosel`

## Requirements
- R1: After synchronous reset both selects are 0 (primary), both loss bits are 0, both event flags are 0 and irq_o is 0.
- R2: A monitored clock is reported lost (loss bit 1) once LOSS_CYCLES system cycles pass with no synchronized rising edge. A clock whose rising edges come closer together than that is never reported lost.
- R3: A lost clock is reported active again on the first synchronized rising edge after the loss.
- R4: With auto_en_i = 1, loss of the primary clock sets tx_sel_o to 1 (oscillator output).
- R5: With auto_en_i = 1, return of the primary clock sets tx_sel_o back to 0, and ref_sel_o back to 0 as well.
- R6: With auto_en_i = 1, loss of the primary clock sets ref_sel_o to 1 (fallback clock).
- R7: With auto_en_i = 0, both selects are 0 one cycle later, even while the primary clock is lost.
- R8: Every change of tx_sel_o sets evt_o[0], and every change of ref_sel_o sets evt_o[1]. This includes changes forced by clearing auto_en_i. The flags stay set until they are cleared.
- R9: A 1 in bit k of evt_clr_i clears evt_o[k] at the next clock edge, unless a select change sets it in that same cycle. A 0 in bit k leaves evt_o[k] unchanged.
- R10: irq_o is 1 exactly when some evt_o[k] is 1 while evt_mask_i[k] is 0.
- R11: Loss of the fallback clock sets fb_lost_o and changes neither select nor any event flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the monitored clocks |
| rst_i | input | 1 | Synchronous reset, active high |
| pri_clk_i | input | 1 | Primary transmit clock, monitored (asynchronous) |
| fb_clk_i | input | 1 | Fallback reference clock, monitored (asynchronous) |
| auto_en_i | input | 1 | Enables automatic source switching for both selects |
| evt_mask_i | input | 2 | Per-flag interrupt mask, 1 masks the flag |
| evt_clr_i | input | 2 | Write-1-to-clear strobes for the event flags |
| tx_sel_o | output | 1 | Transmit clock select: 0 primary, 1 oscillator |
| ref_sel_o | output | 1 | Oscillator reference select: 0 primary, 1 fallback |
| pri_lost_o | output | 1 | Primary clock currently lost |
| fb_lost_o | output | 1 | Fallback clock currently lost |
| evt_o | output | 2 | Sticky event flags: bit 0 transmit select, bit 1 reference select |
| irq_o | output | 1 | OR of unmasked event flags |

## Verification
The bench runs both monitored clocks with edge gaps just under the loss limit. A detector that counted too few cycles would flag a healthy clock there. It clears auto_en_i while the primary clock is still lost. A design that kept the selects on the alternate sources, or that raised the event flags only on loss-driven changes, would fail that step. It clears one flag at a time and toggles the masks. A shared clear strobe or a mask applied to the wrong flag would then show up on evt_o or irq_o. It also stops the fallback clock alone, which catches a design that lets the fallback loss drive either select.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
  // Source choice carried by each select line.
  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_ALT = 1'b1
  } src_e;

  localparam int unsigned NUM_MON = 2;  // monitored clocks: 0 primary, 1 fallback
  localparam int unsigned NUM_SEL = 2;  // selects: 0 transmit, 1 reference
  localparam int unsigned MON_PRI = 0;
  localparam int unsigned MON_FB  = 1;
endpackage

// File: rtl/clk_act_mon.sv
module clk_act_mon #(
  parameter int unsigned LOSS_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mon_clk_i,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          gap_q;
  logic                   lost_q;
  logic                   rise;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], mon_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // Gap counter: cycles since the last rising edge; saturates at the limit.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q  <= '0;
      lost_q <= 1'b0;
    end else if (rise) begin
      gap_q  <= '0;
      lost_q <= 1'b0;
    end else if (gap_q == LIMIT) begin
      lost_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign lost_o = lost_q;

  // R3: an edge always brings the clock back to active.
  p_edge_clears_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    rise |=> !lost_o);
  // R2: loss is only declared in a cycle without an edge.
  p_loss_needs_gap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lost_o) |-> $past(!rise));
endmodule

// File: rtl/src_sel_ctl.sv
module src_sel_ctl
  import txsel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic auto_en_i,
  input  logic pri_lost_i,
  output src_e sel_o,
  output logic chg_o
);
  src_e sel_q, sel_nxt;

  always_comb begin
    sel_nxt = SRC_PRI;
    if (auto_en_i && pri_lost_i) sel_nxt = SRC_ALT;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sel_q <= SRC_PRI;
    else       sel_q <= sel_nxt;
  end

  assign sel_o = sel_q;
  assign chg_o = (sel_nxt != sel_q);

  // R7: with switching disabled the select returns to the primary source.
  p_disabled_primary_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !auto_en_i |=> sel_o == SRC_PRI);
  // R4 / R6: enabled switching leaves the primary source on loss.
  p_loss_moves_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (auto_en_i && pri_lost_i) |=> sel_o == SRC_ALT);
  // R5: with the primary clock present the select is primary.
  p_revert_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !pri_lost_i |=> sel_o == SRC_PRI);
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;

  // Set wins over a simultaneous clear so no event is lost.
  always_ff @(posedge clk_i) begin
    if (rst_i) flags_q <= '0;
    else       flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ~mask_i);

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R8: a set request is always recorded.
    p_set_sticks_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      set_i[k] |=> flags_o[k]);
    // R9: without set or clear, a flag holds its value.
    p_flag_holds_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (!set_i[k] && !clr_i[k]) |=> $stable(flags_o[k]));
  end
endmodule

// File: rtl/txclk_autosel.sv
module txclk_autosel
  import txsel_pkg::*;
#(
  parameter int unsigned LOSS_CYCLES = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pri_clk_i,
  input  logic       fb_clk_i,
  input  logic       auto_en_i,
  input  logic [1:0] evt_mask_i,
  input  logic [1:0] evt_clr_i,
  output logic       tx_sel_o,
  output logic       ref_sel_o,
  output logic       pri_lost_o,
  output logic       fb_lost_o,
  output logic [1:0] evt_o,
  output logic       irq_o
);
  logic [NUM_MON-1:0] mon_clk;
  logic [NUM_MON-1:0] mon_lost;
  src_e               sel    [NUM_SEL];
  logic [NUM_SEL-1:0] sel_chg;

  assign mon_clk[MON_PRI] = pri_clk_i;
  assign mon_clk[MON_FB]  = fb_clk_i;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    clk_act_mon #(
      .LOSS_CYCLES(LOSS_CYCLES),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .mon_clk_i(mon_clk[m]),
      .lost_o   (mon_lost[m])
    );
  end

  // Both selects follow the shared primary-loss detector.
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    src_sel_ctl u_ctl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .auto_en_i (auto_en_i),
      .pri_lost_i(mon_lost[MON_PRI]),
      .sel_o     (sel[s]),
      .chg_o     (sel_chg[s])
    );
  end

  evt_flags #(.N(NUM_SEL)) u_evt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (sel_chg),
    .clr_i  (evt_clr_i),
    .mask_i (evt_mask_i),
    .flags_o(evt_o),
    .irq_o  (irq_o)
  );

  assign tx_sel_o   = sel[0];
  assign ref_sel_o  = sel[1];
  assign pri_lost_o = mon_lost[MON_PRI];
  assign fb_lost_o  = mon_lost[MON_FB];

  // R8: each select change leaves its flag set.
  p_tx_change_flag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_sel_o != $past(tx_sel_o)) |-> evt_o[0]);
  p_ref_change_flag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ref_sel_o != $past(ref_sel_o)) |-> evt_o[1]);
  // R11: fallback loss alone never moves the selects.
  p_fb_no_effect_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pri_lost_o && $past(!pri_lost_o)) |-> (!tx_sel_o && !ref_sel_o));
endmodule

// File: tb/txclk_autosel_tb.sv
module txclk_autosel_tb;
  localparam int unsigned LOSS = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       pri_clk = 1'b0, fb_clk = 1'b0;
  logic       pri_run, fb_run;
  logic       auto_en;
  logic [1:0] mask, clr;
  logic       tx_sel, ref_sel, pri_lost, fb_lost, irq;
  logic [1:0] evt;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // Expected item: {pri_lost, fb_lost, tx_sel, ref_sel, evt[1:0], irq}
  typedef struct {
    string      req;
    logic [6:0] val;
  } exp_t;
  exp_t sbq[$];
  event chk_ev;

  always #2 clk = ~clk;  // 250 MHz
  initial forever begin #20; if (pri_run) pri_clk = ~pri_clk; end  // 10 cycles per period
  initial forever begin #28; if (fb_run)  fb_clk  = ~fb_clk;  end  // 14 cycles per period

  txclk_autosel #(.LOSS_CYCLES(LOSS), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_i(rst), .pri_clk_i(pri_clk), .fb_clk_i(fb_clk),
    .auto_en_i(auto_en), .evt_mask_i(mask), .evt_clr_i(clr),
    .tx_sel_o(tx_sel), .ref_sel_o(ref_sel), .pri_lost_o(pri_lost),
    .fb_lost_o(fb_lost), .evt_o(evt), .irq_o(irq)
  );

  // Monitor: pops expected items and compares with the outputs.
  initial forever begin
    @(chk_ev);
    while (sbq.size() > 0) begin
      exp_t e;
      logic [6:0] act;
      e = sbq.pop_front();
      act = {pri_lost, fb_lost, tx_sel, ref_sel, evt, irq};
      n_vec++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b (pl fl tx ref evt1 evt0 irq)",
                 e.req, act, e.val);
      end
    end
  end

  task automatic expect_now(input string req, input logic pl, input logic fl,
                            input logic tx, input logic rf, input logic [1:0] ev,
                            input logic iq);
    exp_t e;
    e.req = req;
    e.val = {pl, fl, tx, rf, ev, iq};
    sbq.push_back(e);
    ->chk_ev;
    #0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [1:0] b);
    clr = b;
    cyc(1);
    clr = 2'b00;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pri_run = 1'b1; fb_run = 1'b1;
    auto_en = 1'b1; mask = 2'b00; clr = 2'b00;
    cyc(4);
    expect_now("R1 reset state", 0, 0, 0, 0, 2'b00, 0);
    rst = 1'b0;
    cyc(120);
    expect_now("R2 short edge gaps not lost", 0, 0, 0, 0, 2'b00, 0);

    // Primary loss with auto switching.
    pri_run = 1'b0;
    cyc(LOSS / 2);
    expect_now("R2 not lost before limit", 0, 0, 0, 0, 2'b00, 0);
    cyc(40);
    expect_now("R4 R6 switch on loss", 1, 0, 1, 1, 2'b11, 1);

    pulse_clr(2'b01);
    expect_now("R9 clear flag 0 only", 1, 0, 1, 1, 2'b10, 1);
    mask = 2'b10;
    cyc(1);
    expect_now("R10 masked flag no irq", 1, 0, 1, 1, 2'b10, 0);
    pulse_clr(2'b10);
    mask = 2'b00;
    cyc(1);
    expect_now("R9 clear flag 1", 1, 0, 1, 1, 2'b00, 0);

    // Primary returns.
    pri_run = 1'b1;
    cyc(30);
    expect_now("R3 R5 revert on return", 0, 0, 0, 0, 2'b11, 1);
    mask = 2'b11;
    cyc(1);
    expect_now("R10 all masked", 0, 0, 0, 0, 2'b11, 0);
    mask = 2'b00;
    pulse_clr(2'b11);
    expect_now("R9 clear both", 0, 0, 0, 0, 2'b00, 0);

    // Loss again, then disable while still lost.
    pri_run = 1'b0;
    cyc(50);
    expect_now("R4 second loss", 1, 0, 1, 1, 2'b11, 1);
    pulse_clr(2'b11);
    expect_now("R9 cleared while lost", 1, 0, 1, 1, 2'b00, 0);
    auto_en = 1'b0;
    cyc(1);
    expect_now("R7 R8 forced primary raises flags", 1, 0, 0, 0, 2'b11, 1);
    pulse_clr(2'b11);
    cyc(20);
    expect_now("R7 stays primary while lost", 1, 0, 0, 0, 2'b00, 0);

    // Primary back, fallback lost.
    pri_run = 1'b1;
    cyc(30);
    expect_now("R3 primary active again", 0, 0, 0, 0, 2'b00, 0);
    auto_en = 1'b1;
    fb_run = 1'b0;
    cyc(60);
    expect_now("R11 fallback loss no select change", 0, 1, 0, 0, 2'b00, 0);
    fb_run = 1'b1;
    cyc(40);
    expect_now("R3 fallback recovers", 0, 0, 0, 0, 2'b00, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule